// File: doc/BRIEF.md
# Redundant Signed-Digit Value Comparator

This block orders two operands held in radix-2 redundant signed-digit form. Each operand has N digits, and each digit is a two-bit code whose value is -1, 0 or +1. The block compares the operands by numeric value, not by bit pattern, so two operands that encode the same number in different ways are reported as equal. One clock edge after a valid strobe, it raises exactly one of three flags: greater, equal or less.

The block decodes every digit position in parallel into a positive-digit mask and a negative-digit mask. It forms each operand's value as the difference of the two masks in signed arithmetic that is two bits wider than N. It then compares the two values. There is one register stage, at the outputs. An arithmetic unit built on signed digits can use the block to evaluate a condition without first converting its operands to binary.

Top module: `rsd_cmp`

## Requirements
- R1: Digit k of an operand sits in bits [2k+1:2k]. Code 00 means -1, codes 01 and 10 both mean 0, and code 11 means +1.
- R2: The value of an operand is the sum over k of digit_k times 2^k. Digit 0 has weight 1.
- R3: An operand may be negative. The extremes, all digits 11 (+(2^N-1)) and all digits 00 (-(2^N-1)), compare correctly against each other and against themselves.
- R4: Operands with different bit patterns but the same value give eq=1. Examples are the swap of 01 and 10 in any digit, and the pair +1,-1 placed against the pair 0,+1.
- R5: Whenever out_valid is 1, exactly one of gt, eq and lt is 1.
- R6: gt=1 when value(A) > value(B). lt=1 when value(A) < value(B). eq=1 when the two values are equal.
- R7: out_valid on a clock edge equals in_valid at the previous edge. The flags then show the operands that were sampled at that previous edge.
- R8: At an edge where in_valid is 0, the flags keep their previous values whatever the operand inputs are.
- R9: While the synchronous active-high reset is sampled high, gt, eq, lt and out_valid are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid on this edge |
| opa | input | 2*N | Operand A, two bits per digit |
| opb | input | 2*N | Operand B, two bits per digit |
| out_valid | output | 1 | Flags hold a new result |
| gt | output | 1 | A greater than B |
| eq | output | 1 | A equal to B in value |
| lt | output | 1 | A less than B |

## Verification
The assertions assume that reset is held for at least one edge before the first comparison and that the operand buses carry no X or Z while in_valid is high. Every code in {00, 01, 10, 11} is legal, so the assertions place no limit on digit values. The stimulus always drives defined values, starting with reset asserted. It covers every digit pair exhaustively on a two-digit instance, and on the eight-digit instance it sends random operands, operands re-encoded to the same value, and the two extremes. Gaps in in_valid are inserted while the operands keep changing, which exercises the hold behaviour.

// File: rtl/rsd_cmp.sv
module rsd_cmp #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2*N-1:0] opa,
  input  logic [2*N-1:0] opb,
  output logic           out_valid,
  output logic           gt,
  output logic           eq,
  output logic           lt
);
  localparam int W = N + 2;

  logic [N-1:0] pos_a, neg_a, pos_b, neg_b;

  for (genvar k = 0; k < N; k++) begin : g_dig
    assign pos_a[k] =   opa[2*k+1] &  opa[2*k];
    assign neg_a[k] = ~(opa[2*k+1] |  opa[2*k]);
    assign pos_b[k] =   opb[2*k+1] &  opb[2*k];
    assign neg_b[k] = ~(opb[2*k+1] |  opb[2*k]);
  end

  logic signed [W-1:0] val_a, val_b;
  assign val_a = $signed({2'b00, pos_a}) - $signed({2'b00, neg_a});
  assign val_b = $signed({2'b00, pos_b}) - $signed({2'b00, neg_b});

  logic a_gt, a_lt;
  assign a_gt = val_a > val_b;
  assign a_lt = val_a < val_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      gt        <= 1'b0;
      eq        <= 1'b0;
      lt        <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        gt <= a_gt;
        lt <= a_lt;
        eq <= ~(a_gt | a_lt);
      end
    end
  end
endmodule

// File: rtl/rsd_cmp_chk.sv
module rsd_cmp_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [2*N-1:0] opa,
  input logic [2*N-1:0] opb,
  input logic           out_valid,
  input logic           gt,
  input logic           eq,
  input logic           lt
);
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({gt, eq, lt}) == 1); // R5

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && $past(!rst)) |=> $stable({gt, eq, lt})); // R8

  AST_SAME_BITS_EQ: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opa == opb) |=> eq); // R4

  AST_ALL_PLUS_GT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && &opa && opb == '0) |=> gt); // R3
endmodule

bind rsd_cmp rsd_cmp_chk #(.N(N)) u_chk (.*);

// File: tb/sim_rsd_cmp.sv
module sim_rsd_cmp;
  localparam int NB = 8;
  localparam int NS = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, v8, v2;
  logic [2*NB-1:0] a8, b8;
  logic [2*NS-1:0] a2, b2;
  logic o8v, g8, e8, l8, o2v, g2, e2, l2;

  rsd_cmp #(.N(NB)) u0 (.clk(clk), .rst(rst), .in_valid(v8), .opa(a8), .opb(b8),
                        .out_valid(o8v), .gt(g8), .eq(e8), .lt(l8));
  rsd_cmp #(.N(NS)) u1 (.clk(clk), .rst(rst), .in_valid(v2), .opa(a2), .opb(b2),
                        .out_valid(o2v), .gt(g2), .eq(e2), .lt(l2));

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m8 = '0;
  logic [3:0] m2 = '0;

  function automatic int dval(logic [15:0] x, int n);
    int s = 0;
    for (int k = 0; k < n; k++)
      case (x[2*k +: 2])
        2'b00: s -= (1 << k);
        2'b11: s += (1 << k);
        default: ;
      endcase
    return s;
  endfunction

  function automatic logic [3:0] step(logic [3:0] m, logic v, int d);
    logic [3:0] r = m;
    r[3] = v;
    if (v) r[2:0] = {d > 0, d == 0, d < 0};
    return r;
  endfunction

  task automatic check(string tag, string who, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: {vld,gt,eq,lt} got %b expected %b", tag, who, got, exp);
    end
  endtask

  task automatic tick(string tag);
    int d8 = dval(16'(a8), NB) - dval(16'(b8), NB);
    int d2 = dval(16'(a2), NS) - dval(16'(b2), NS);
    @(negedge clk);
    if (rst) begin
      m8 = '0;
      m2 = '0;
    end else begin
      m8 = step(m8, v8, d8);
      m2 = step(m2, v2, d2);
    end
    check(tag, "N8", {o8v, g8, e8, l8}, m8);
    check(tag, "N2", {o2v, g2, e2, l2}, m2);
  endtask

  function automatic logic [2*NB-1:0] reenc(logic [2*NB-1:0] x, logic [NB-1:0] sel);
    logic [2*NB-1:0] y = x;
    for (int k = 0; k < NB; k++)
      if (sel[k] && (x[2*k +: 2] == 2'b01 || x[2*k +: 2] == 2'b10))
        y[2*k +: 2] = ~x[2*k +: 2];
    return y;
  endfunction

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; v8 = 1'b1; v2 = 1'b1;
    a8 = 16'hFFFF; b8 = '0; a2 = 4'hF; b2 = 4'h0;
    tick("R9");
    tick("R9");
    rst = 1'b0;

    // exhaustive two-digit pairs: R1 R2 R6, R5 on every result
    for (int ia = 0; ia < 16; ia++)
      for (int ib = 0; ib < 16; ib++) begin
        a2 = 4'(ia); b2 = 4'(ib); v2 = 1'b1;
        a8 = 16'($urandom); b8 = 16'($urandom); v8 = 1'b1;
        tick("R1");
      end
    v2 = 1'b0;

    a8 = 16'hFFFF; b8 = 16'h0000; tick("R3");
    a8 = 16'h0000; b8 = 16'hFFFF; tick("R3");
    a8 = 16'h0000; b8 = 16'h0000; tick("R3");
    a8 = 16'hFFFF; b8 = 16'hFFFF; tick("R3");
    a8 = 16'h5555; b8 = 16'hAAAA; tick("R4");
    a8 = 16'h5557; b8 = 16'h555C; tick("R4");
    a8 = 16'h7555; b8 = 16'hC555; tick("R2");
    a8 = 16'h5554; b8 = 16'h5556; tick("R5");

    v8 = 1'b0; a8 = 16'h0000; b8 = 16'hFFFF;
    tick("R8");
    a8 = 16'hFFFF; b8 = 16'h0000;
    tick("R8");
    v8 = 1'b1; tick("R7");

    for (int i = 0; i < 400; i++) begin
      a8 = 16'($urandom); b8 = 16'($urandom);
      v8 = ($urandom % 4) != 0;
      tick("R6");
    end

    for (int i = 0; i < 200; i++) begin
      a8 = 16'($urandom);
      b8 = reenc(a8, 8'($urandom));
      v8 = 1'b1;
      tick("R4");
    end

    rst = 1'b1; tick("R9");
    rst = 1'b0; v8 = 1'b0; tick("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule